// File: doc/BRIEF.md
# Indexed Interrupt Mask and Priority Selector

This block is the front end of an interrupt controller for 64 sources. Software never writes the mask bitmap itself. To change one mask bit it writes a source number to one of two command addresses. One command masks that source and the other unmasks it. The value 0xFF applies either command to every source at once. Each source also has a byte-wide level register that sets its priority.

Every cycle, the block looks at the pending inputs that are not masked and reports the one with the highest level, together with that level. When several sources share the highest level, the lowest source number wins. The full mask vector is always visible on an output. Any level register can be read back through a read port.

Top module: `imask_unit`

## Requirements
- R1: After reset every mask bit is 1, every level register reads 0, and the valid output is low.
- R2: A write to address 0x40 with a value n from 0 to 63 sets mask bit n in the next cycle. All other mask bits keep their values.
- R3: A write to address 0x41 with a value n from 0 to 63 clears mask bit n in the next cycle. All other mask bits keep their values.
- R4: A write of 0xFF to address 0x40 sets all 64 mask bits.
- R5: A write of 0xFF to address 0x41 clears all 64 mask bits.
- R6: A value from 64 to 254 written to address 0x40 or 0x41 leaves the mask unchanged.
- R7: A write to address n (0 to 63) stores bits 2:0 of the data as the level of source n. The read port returns that level zero-extended to 8 bits. Writes to addresses 0x42 to 0xFF change no register.
- R8: A source is a candidate when it is pending, unmasked, and has a nonzero level. The outputs name the candidate with the highest level and give that level.
- R9: Among candidates that share the highest level, the lowest source number is selected.
- R10: When there is no candidate, the valid output is low and the source and level outputs are 0. A level of 0 keeps a source from ever being selected.
- R11: The selection outputs follow the pending inputs within the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address: 0..63 selects a level register, 0x40 is the mask command, 0x41 is the unmask command |
| wr_data | input | 8 | Write data: a level, a source number, or 0xFF |
| pend_i | input | 64 | Pending interrupt inputs, one bit per source |
| rd_addr | input | 6 | Source whose level register is read |
| rd_level | output | 8 | Level of the source selected by rd_addr, zero-extended |
| mask_o | output | 64 | Current mask vector; a 1 blocks the source |
| win_valid_o | output | 1 | High when at least one candidate exists |
| win_src_o | output | 6 | Number of the selected source |
| win_lvl_o | output | 3 | Level of the selected source |

## Verification
The bench builds the block with its default sizes: 64 sources and 3-bit levels. With these sizes the command range ends exactly at 63. This lets the bench write the edge values 63, 64, 254 and 255, and pair source 63 with source 0 in the priority checks. The 3-bit level means a data byte with its upper bits set shows whether those bits are dropped. The priority checks place equal top levels on distant sources, so a wrong tie-break rule gives a visible wrong answer.

// File: rtl/imask_pkg.sv
package imask_pkg;

    localparam logic [7:0] SET_ADDR = 8'h40;
    localparam logic [7:0] CLR_ADDR = 8'h41;
    localparam logic [7:0] ALL_CODE = 8'hFF;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LEVEL,
        OP_SET,
        OP_CLEAR
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [7:0] idx;
        logic [7:0] arg;
    } wcmd_t;

    function automatic wcmd_t decode_write(input logic en, input logic [7:0] addr,
                                           input logic [7:0] data, input logic [7:0] nsrc);
        wcmd_t c;
        c.idx = addr;
        c.arg = data;
        c.op  = OP_NONE;
        if (en) begin
            if (addr < nsrc)           c.op = OP_LEVEL;
            else if (addr == SET_ADDR) c.op = OP_SET;
            else if (addr == CLR_ADDR) c.op = OP_CLEAR;
        end
        return c;
    endfunction

endpackage

// File: rtl/imask_bits.sv
module imask_bits
    import imask_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int SRC_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  wcmd_t              cmd,
    output logic [NUM_SRC-1:0] mask_q
);
    localparam logic [7:0] LIMIT = 8'(NUM_SRC);

    logic in_range;
    assign in_range = cmd.arg < LIMIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (cmd.op == OP_SET) begin
            if (cmd.arg == ALL_CODE)  mask_q <= '1;
            else if (in_range)        mask_q[cmd.arg[SRC_W-1:0]] <= 1'b1;
        end else if (cmd.op == OP_CLEAR) begin
            if (cmd.arg == ALL_CODE)  mask_q <= '0;
            else if (in_range)        mask_q[cmd.arg[SRC_W-1:0]] <= 1'b0;
        end
    end

    // R2
    set_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_SET && cmd.arg < LIMIT) |=> mask_q[$past(cmd.arg[SRC_W-1:0])]);
    // R3
    clr_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_CLEAR && cmd.arg < LIMIT) |=> !mask_q[$past(cmd.arg[SRC_W-1:0])]);
    // R4
    set_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_SET && cmd.arg == ALL_CODE) |=> (&mask_q));
    // R5
    clr_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_CLEAR && cmd.arg == ALL_CODE) |=> (mask_q == '0));
    // R6
    ignore_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd.op == OP_SET || cmd.op == OP_CLEAR) && cmd.arg >= LIMIT && cmd.arg != ALL_CODE)
        |=> $stable(mask_q));
endmodule

// File: rtl/imask_levels.sv
module imask_levels
    import imask_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int LVL_W = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  wcmd_t                         cmd,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst)
                lvl_q[g] <= '0;
            else if (cmd.op == OP_LEVEL && cmd.idx == 8'(g))
                lvl_q[g] <= cmd.arg[LVL_W-1:0];
        end
    end

    // R7
    lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.op != OP_LEVEL) |=> $stable(lvl_q));
endmodule

// File: rtl/imask_select.sv
module imask_select #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W = 3,
    localparam int SRC_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            pend,
    input  logic [NUM_SRC-1:0]            mask,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    output logic                          valid,
    output logic [SRC_W-1:0]              src,
    output logic [LVL_W-1:0]              best
);
    always_comb begin
        valid = 1'b0;
        src   = '0;
        best  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && !mask[i] && lvl[i] > best) begin
                valid = 1'b1;
                src   = SRC_W'(i);
                best  = lvl[i];
            end
        end
    end
endmodule

// File: rtl/imask_unit.sv
module imask_unit
    import imask_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int LVL_W = 3,
    localparam int SRC_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [7:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [SRC_W-1:0]   rd_addr,
    output logic [7:0]         rd_level,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               win_valid_o,
    output logic [SRC_W-1:0]   win_src_o,
    output logic [LVL_W-1:0]   win_lvl_o
);
    wcmd_t cmd;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;

    assign cmd = decode_write(wr_en, wr_addr, wr_data, 8'(NUM_SRC));

    imask_bits #(.NUM_SRC(NUM_SRC)) u_bits (
        .clk(clk), .rst(rst), .cmd(cmd), .mask_q(mask_o)
    );

    imask_levels #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_levels (
        .clk(clk), .rst(rst), .cmd(cmd), .lvl_q(lvl)
    );

    imask_select #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_sel (
        .pend(pend_i), .mask(mask_o), .lvl(lvl),
        .valid(win_valid_o), .src(win_src_o), .best(win_lvl_o)
    );

    assign rd_level = 8'(lvl[rd_addr]);

    // R8
    win_legal_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid_o |-> (pend_i[win_src_o] && !mask_o[win_src_o] && win_lvl_o != '0));
    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !win_valid_o |-> (win_src_o == '0 && win_lvl_o == '0));
    // R1
    reset_mask_chk: assert property (@(posedge clk)
        $past(rst) |-> (&mask_o && !win_valid_o));
endmodule

// File: tb/test_imask_unit.sv
module test_imask_unit;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [N-1:0] pend_i = '0;
    logic [5:0]  rd_addr = '0;
    logic [7:0]  rd_level;
    logic [N-1:0] mask_o;
    logic        win_valid_o;
    logic [5:0]  win_src_o;
    logic [2:0]  win_lvl_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [N-1:0] exp_mask;
    logic [2:0]   exp_lvl [N];

    always #5 clk = ~clk;

    imask_unit i_imask_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pend_i(pend_i), .rd_addr(rd_addr), .rd_level(rd_level), .mask_o(mask_o),
        .win_valid_o(win_valid_o), .win_src_o(win_src_o), .win_lvl_o(win_lvl_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_winner(input string req);
        logic v; logic [5:0] s; logic [2:0] l;
        v = 0; s = '0; l = '0;
        for (int i = 0; i < N; i++)
            if (pend_i[i] && !exp_mask[i] && exp_lvl[i] > l) begin
                v = 1; s = 6'(i); l = exp_lvl[i];
            end
        #1;
        check(req, {54'd0, win_valid_o, win_src_o, win_lvl_o}, {54'd0, v, s, l});
    endtask

    task automatic check_levels(input string req);
        logic ok; ok = 1;
        for (int i = 0; i < N; i++) begin
            rd_addr = 6'(i); #1;
            if (rd_level !== {5'd0, exp_lvl[i]}) ok = 0;
        end
        check(req, {63'd0, ok}, 64'd1);
    endtask

    task automatic t_reset;
        check("R1 mask", mask_o, '1);
        check("R1 valid", {63'd0, win_valid_o}, 64'd0);
        check_levels("R1 levels");
    endtask

    task automatic t_single;
        wr(8'h41, 8'd0);  exp_mask[0] = 0;
        wr(8'h41, 8'd63); exp_mask[63] = 0;
        wr(8'h41, 8'd17); exp_mask[17] = 0;
        check("R3 clear single", mask_o, exp_mask);
        wr(8'h40, 8'd17); exp_mask[17] = 1;
        check("R2 set single", mask_o, exp_mask);
        wr(8'h40, 8'd63); exp_mask[63] = 1;
        check("R2 set 63", mask_o, exp_mask);
    endtask

    task automatic t_all_ignore;
        wr(8'h41, 8'hFF); exp_mask = '0;
        check("R5 clear all", mask_o, exp_mask);
        wr(8'h40, 8'd64); wr(8'h40, 8'd200); wr(8'h40, 8'd254);
        check("R6 set ignored", mask_o, exp_mask);
        wr(8'h40, 8'hFF); exp_mask = '1;
        check("R4 set all", mask_o, exp_mask);
        wr(8'h41, 8'd64); wr(8'h41, 8'd254);
        check("R6 clear ignored", mask_o, exp_mask);
    endtask

    task automatic t_levels;
        wr(8'd3, 8'd5);    exp_lvl[3] = 3'd5;
        wr(8'd10, 8'hFF);  exp_lvl[10] = 3'd7;
        wr(8'd40, 8'd7);   exp_lvl[40] = 3'd7;
        wr(8'd63, 8'd2);   exp_lvl[63] = 3'd2;
        wr(8'd0, 8'd1);    exp_lvl[0] = 3'd1;
        check_levels("R7 stored levels");
        wr(8'h80, 8'd6); wr(8'h42, 8'd6);
        check_levels("R7 unmapped writes ignored");
        check("R7 unmapped mask", mask_o, exp_mask);
    endtask

    task automatic t_prio;
        wr(8'h41, 8'hFF); exp_mask = '0;
        @(negedge clk);
        pend_i = '0; pend_i[3] = 1; pend_i[10] = 1; pend_i[40] = 1; pend_i[63] = 1;
        check_winner("R9 tie lowest");
        pend_i[10] = 0; pend_i[40] = 0;
        check_winner("R8 highest R11 same cycle");
        pend_i = '0; pend_i[63] = 1; pend_i[0] = 1;
        check_winner("R8 source 63");
        pend_i = '0; pend_i[3] = 1; pend_i[10] = 1; pend_i[40] = 1;
        wr(8'h40, 8'd10); exp_mask[10] = 1;
        check_winner("R2 masked source skipped");
    endtask

    task automatic t_none;
        pend_i = '0; pend_i[5] = 1; pend_i[20] = 1;
        check_winner("R10 level zero");
        pend_i = '0;
        check_winner("R10 nothing pending");
        pend_i = '1;
        wr(8'h40, 8'hFF); exp_mask = '1;
        check_winner("R10 all masked");
    endtask

    initial begin
        exp_mask = '1;
        for (int i = 0; i < N; i++) exp_lvl[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_all_ignore();
        t_levels();
        t_prio();
        t_none();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule